// File: doc/BRIEF.md
# USB High-Speed Handshake Sequencer

This block sits in the link layer of a USB device and runs the high-speed detection handshake through the mode pins of a transceiver control interface. A one-cycle pulse on `hs_reset_start` marks the start of a bus reset. The block answers by moving the transceiver out of full-speed mode into raw transmit mode: bit stuffing and NRZI are off, the transceiver select is high-speed, and an all-zero byte stream is sent, which the bus sees as a steady K. This device chirp lasts a parameterised number of clock cycles. At the 60 MHz default this is 2.0 ms, and the length is forced into the window from 1.0 ms after reset start to 7.0 ms after reset start.

Listening starts together with the chirp. `listen_en` enables a separate validator, which watches the host's alternating chirp pattern and returns one verdict pulse (`vfy_done`, with `vfy_pass` giving the result). A passing verdict switches the terminations to high-speed. A failing verdict, or no verdict within `VERDICT_TIMEOUT_CYC` cycles of the end of the chirp, returns the transceiver to full-speed. Both final states are kept until the next reset-start pulse. A reset-start pulse restarts the handshake from any state.

Top module: `hs_handshake_seq`

## Requirements
- R1: After reset, and in the idle state before any `hs_reset_start` pulse, the outputs are `xcvr_fs`=1, `term_fs`=1, `opmode`=2'b00, `tx_valid`=0, `listen_en`=0 and `hs_ready`=0. A verdict pulse in the idle state changes none of them.
- R2: In the cycle after `hs_reset_start` is sampled, the block is chirping. The outputs are `xcvr_fs`=0, `term_fs`=1, `opmode`=2'b10 (no bit stuffing and no NRZI), `tx_valid`=1, `tx_data`=8'h00 and `listen_en`=1.
- R3: The chirp outputs last exactly CHIRP_LEN cycles after the cycle in which `hs_reset_start` was sampled. CHIRP_LEN is `CHIRP_CYC` forced into the range [`MIN_CHIRP_CYC`, `MAX_CHIRP_END_CYC`].
- R4: When the chirp ends without a stored verdict, the outputs become `opmode`=2'b00, `tx_valid`=0, `xcvr_fs`=0, `term_fs`=1 and `listen_en`=1.
- R5: A `vfy_done` pulse with `vfy_pass`=1 while listening gives `term_fs`=0, `xcvr_fs`=0, `hs_ready`=1 and `listen_en`=0 in the next cycle.
- R6: A `vfy_done` pulse with `vfy_pass`=0 while listening gives `xcvr_fs`=1, `term_fs`=1, `listen_en`=0 and `hs_ready`=0 in the next cycle.
- R7: With no verdict during the `VERDICT_TIMEOUT_CYC` listening cycles after the chirp, the block falls back to full-speed outputs (as in R6). A verdict in the last listening cycle takes priority over the timeout.
- R8: The first verdict that arrives during the chirp is stored and takes effect when the chirp ends, moving the block straight to the R5 or R6 outputs. The chirp is not shortened.
- R9: An `hs_reset_start` pulse in any state restarts a full-length chirp as in R2 and R3. It also drops any stored verdict.
- R10: The high-speed and full-speed fallback states ignore further verdict pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, 60 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_reset_start | input | 1 | One-cycle pulse at the start of a bus reset |
| vfy_done | input | 1 | Verdict strobe from the host chirp validator |
| vfy_pass | input | 1 | Verdict result, 1 = valid host chirp pattern |
| xcvr_fs | output | 1 | Transceiver select, 1 = full-speed, 0 = high-speed |
| term_fs | output | 1 | Termination select, 1 = full-speed with pull-up, 0 = high-speed |
| opmode | output | 2 | 2'b00 normal, 2'b10 no bit stuffing and no NRZI |
| tx_valid | output | 1 | Transmit valid, high during the device chirp |
| tx_data | output | 8 | Transmit byte, all zeros |
| listen_en | output | 1 | Enables the host chirp validator |
| hs_ready | output | 1 | High-speed handshake completed |

## Verification
All outputs come from registers, so each reacts one cycle after the input edge that causes it. The chirp outputs are due one cycle after `hs_reset_start`. Each verdict shows its effect one cycle after it is sampled. The chirp ends exactly CHIRP_LEN cycles after the restart edge, and the timeout fires at the `VERDICT_TIMEOUT_CYC`-th listening edge. The bench drives and samples one time unit after each rising edge. It checks the last cycle before every timed transition and the first cycle after it, so an error of one cycle in either direction is caught.

// File: rtl/hs_hsk_pkg.sv
package hs_hsk_pkg;

  typedef enum logic [2:0] {
    HSK_IDLE   = 3'd0,
    HSK_CHIRP  = 3'd1,
    HSK_LISTEN = 3'd2,
    HSK_HIGH   = 3'd3,
    HSK_FULL   = 3'd4
  } hsk_state_e;

  localparam logic [1:0] OPM_NORMAL = 2'b00;
  localparam logic [1:0] OPM_RAW    = 2'b10;
  localparam logic [7:0] CHIRP_BYTE = 8'h00;

  typedef struct packed {
    logic       xcvr_fs;
    logic       term_fs;
    logic [1:0] opmode;
    logic       tx_valid;
    logic       listen;
    logic       hs_ready;
  } hsk_drive_t;

  function automatic hsk_drive_t drive_of(hsk_state_e s);
    hsk_drive_t d;
    d = '{xcvr_fs: 1'b1, term_fs: 1'b1, opmode: OPM_NORMAL,
          tx_valid: 1'b0, listen: 1'b0, hs_ready: 1'b0};
    case (s)
      HSK_CHIRP: begin
        d.xcvr_fs  = 1'b0;
        d.opmode   = OPM_RAW;
        d.tx_valid = 1'b1;
        d.listen   = 1'b1;
      end
      HSK_LISTEN: begin
        d.xcvr_fs = 1'b0;
        d.listen  = 1'b1;
      end
      HSK_HIGH: begin
        d.xcvr_fs  = 1'b0;
        d.term_fs  = 1'b0;
        d.hs_ready = 1'b1;
      end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/hs_hsk_rst_sync.sv
module hs_hsk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/hs_hsk_timer.sv
module hs_hsk_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = clr || (en && (cnt != {W{1'b1}}));

  always_comb begin
    cnt_d = cnt + 1'b1;
    if (clr) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

endmodule

// File: rtl/hs_hsk_fsm.sv
module hs_hsk_fsm
  import hs_hsk_pkg::*;
#(
  parameter int CHIRP_LEN = 16,
  parameter int WAIT_LEN  = 16,
  parameter int W         = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       vfy_done,
  input  logic       vfy_pass,
  input  logic [W-1:0] cnt,
  output hsk_state_e state_q,
  output hsk_state_e state_d,
  output logic       tmr_clr,
  output logic       tmr_en
);

  localparam logic [W-1:0] CHIRP_LAST = W'(CHIRP_LEN - 1);
  localparam logic [W-1:0] WAIT_LAST  = W'(WAIT_LEN - 1);

  logic chirp_last, wait_last;
  logic pend_v_q, pend_ok_q;
  logic eff_v, eff_ok;
  logic pend_en;

  assign chirp_last = (cnt == CHIRP_LAST);
  assign wait_last  = (cnt == WAIT_LAST);
  assign eff_v      = pend_v_q | vfy_done;
  assign eff_ok     = pend_v_q ? pend_ok_q : vfy_pass;
  assign tmr_en     = (state_q == HSK_CHIRP) || (state_q == HSK_LISTEN);
  assign pend_en    = restart || ((state_q == HSK_CHIRP) && vfy_done && !pend_v_q);

  always_comb begin
    state_d = state_q;
    tmr_clr = 1'b0;
    if (restart) begin
      state_d = HSK_CHIRP;
      tmr_clr = 1'b1;
    end else begin
      case (state_q)
        HSK_CHIRP: begin
          if (chirp_last) begin
            tmr_clr = 1'b1;
            if (eff_v) state_d = eff_ok ? HSK_HIGH : HSK_FULL;
            else       state_d = HSK_LISTEN;
          end
        end
        HSK_LISTEN: begin
          if (vfy_done)       state_d = vfy_pass ? HSK_HIGH : HSK_FULL;
          else if (wait_last) state_d = HSK_FULL;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HSK_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q  <= 1'b0;
      pend_ok_q <= 1'b0;
    end else if (pend_en) begin
      pend_v_q  <= !restart;
      pend_ok_q <= !restart && vfy_pass;
    end
  end

  AST_ENTRY_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> state_q == HSK_CHIRP); // R9

  AST_CHIRP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == HSK_CHIRP |-> cnt <= CHIRP_LAST); // R3

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == HSK_LISTEN |-> cnt <= WAIT_LAST); // R7

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HSK_FULL && !restart) |=> state_q == HSK_FULL); // R10

  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HSK_HIGH && !restart) |=> state_q == HSK_HIGH); // R10

endmodule

// File: rtl/hs_hsk_drive.sv
module hs_hsk_drive
  import hs_hsk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  hsk_state_e state_d,
  output hsk_drive_t drv_q
);

  hsk_drive_t drv_d;

  always_comb drv_d = drive_of(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= drive_of(HSK_IDLE);
    else        drv_q <= drv_d;
  end

  AST_RAW_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q.tx_valid |-> (drv_q.opmode == OPM_RAW) && !drv_q.xcvr_fs && drv_q.term_fs); // R2

  AST_HS_TERM_NEEDS_HS_XCVR: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_q.term_fs |-> !drv_q.xcvr_fs); // R5

  AST_TERM_AFTER_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_q.term_fs) |-> $past(drv_q.listen)); // R5

  AST_NO_TX_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q.hs_ready |-> !drv_q.tx_valid && !drv_q.listen); // R5

endmodule

// File: rtl/hs_handshake_seq.sv
module hs_handshake_seq
  import hs_hsk_pkg::*;
#(
  parameter int CHIRP_CYC           = 120000,
  parameter int MIN_CHIRP_CYC       = 60000,
  parameter int MAX_CHIRP_END_CYC   = 420000,
  parameter int VERDICT_TIMEOUT_CYC = 600000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_reset_start,
  input  logic       vfy_done,
  input  logic       vfy_pass,
  output logic       xcvr_fs,
  output logic       term_fs,
  output logic [1:0] opmode,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       listen_en,
  output logic       hs_ready
);

  localparam int CHIRP_LEN = (CHIRP_CYC < MIN_CHIRP_CYC)     ? MIN_CHIRP_CYC :
                             (CHIRP_CYC > MAX_CHIRP_END_CYC) ? MAX_CHIRP_END_CYC :
                             CHIRP_CYC;
  localparam int CNT_MAX   = (CHIRP_LEN > VERDICT_TIMEOUT_CYC) ? CHIRP_LEN : VERDICT_TIMEOUT_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic             rst_sync_n;
  logic             tmr_clr, tmr_en;
  logic [CNT_W-1:0] cnt;
  hsk_state_e       state_q, state_d;
  hsk_drive_t       drv_q;

  hs_hsk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hs_hsk_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .cnt   (cnt)
  );

  hs_hsk_fsm #(
    .CHIRP_LEN (CHIRP_LEN),
    .WAIT_LEN  (VERDICT_TIMEOUT_CYC),
    .W         (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .restart  (hs_reset_start),
    .vfy_done (vfy_done),
    .vfy_pass (vfy_pass),
    .cnt      (cnt),
    .state_q  (state_q),
    .state_d  (state_d),
    .tmr_clr  (tmr_clr),
    .tmr_en   (tmr_en)
  );

  hs_hsk_drive u_drive (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .state_d (state_d),
    .drv_q   (drv_q)
  );

  assign xcvr_fs   = drv_q.xcvr_fs;
  assign term_fs   = drv_q.term_fs;
  assign opmode    = drv_q.opmode;
  assign tx_valid  = drv_q.tx_valid;
  assign tx_data   = CHIRP_BYTE;
  assign listen_en = drv_q.listen;
  assign hs_ready  = drv_q.hs_ready;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == HSK_IDLE) |-> xcvr_fs && term_fs && !listen_en && !tx_valid); // R1

endmodule

// File: tb/hs_handshake_seq_tb.sv
module hs_handshake_seq_tb;

  localparam int CLK_PERIOD = 16;
  localparam int CHIRP_LEN  = 20;
  localparam int TO_LEN     = 30;

  // outputs packed as {xcvr_fs, term_fs, opmode[1:0], tx_valid, listen_en, hs_ready}
  localparam logic [6:0] E_IDLE   = 7'b1_1_00_0_0_0;
  localparam logic [6:0] E_CHIRP  = 7'b0_1_10_1_1_0;
  localparam logic [6:0] E_LISTEN = 7'b0_1_00_0_1_0;
  localparam logic [6:0] E_HS     = 7'b0_0_00_0_0_1;
  localparam logic [6:0] E_FS     = 7'b1_1_00_0_0_0;

  // vector: {in_chirp, pass, none, exp_hs, 4'b0, delay[7:0]}
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 8'd3},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd5},
    {1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'd0},
    {1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 8'd29},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'd0},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 8'd3},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_reset_start = 1'b0;
  logic vfy_done = 1'b0;
  logic vfy_pass = 1'b0;
  logic xcvr_fs, term_fs, tx_valid, listen_en, hs_ready;
  logic [1:0] opmode;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  hs_handshake_seq #(
    .CHIRP_CYC           (CHIRP_LEN),
    .MIN_CHIRP_CYC       (10),
    .MAX_CHIRP_END_CYC   (40),
    .VERDICT_TIMEOUT_CYC (TO_LEN)
  ) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .hs_reset_start (hs_reset_start),
    .vfy_done       (vfy_done),
    .vfy_pass       (vfy_pass),
    .xcvr_fs        (xcvr_fs),
    .term_fs        (term_fs),
    .opmode         (opmode),
    .tx_valid       (tx_valid),
    .tx_data        (tx_data),
    .listen_en      (listen_en),
    .hs_ready       (hs_ready)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {xcvr_fs, term_fs, opmode, tx_valid, listen_en, hs_ready};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic restart();
    hs_reset_start = 1'b1;
    tick(1);
    hs_reset_start = 1'b0;
  endtask

  task automatic verdict(input logic pass);
    vfy_done = 1'b1;
    vfy_pass = pass;
    tick(1);
    vfy_done = 1'b0;
    vfy_pass = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    tick(100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(3);
    check("R1 reset", E_IDLE);
    verdict(1'b1);
    check("R1 idle verdict ignored", E_IDLE);

    for (int v = 0; v < NV; v++) begin
      logic in_chirp, pass, none, exp_hs;
      int dly;
      in_chirp = VEC[v][15];
      pass     = VEC[v][14];
      none     = VEC[v][13];
      exp_hs   = VEC[v][12];
      dly      = int'(VEC[v][7:0]);
      restart();
      check("R2 chirp entry", E_CHIRP);
      checks++;
      if (tx_data !== 8'h00) begin
        errors++;
        $display("FAIL R2: tx_data actual %h expected 00", tx_data);
      end
      if (in_chirp) begin
        tick(dly);
        verdict(pass);
        tick(CHIRP_LEN - 2 - dly);
        check("R8 chirp not shortened", E_CHIRP);
        tick(1);
        check("R8 stored verdict", exp_hs ? E_HS : E_FS);
      end else begin
        tick(CHIRP_LEN - 1);
        check("R3 last chirp cycle", E_CHIRP);
        tick(1);
        check("R4 listen after chirp", E_LISTEN);
        if (none) begin
          tick(TO_LEN - 1);
          check("R7 still listening", E_LISTEN);
          tick(1);
          check("R7 timeout fallback", E_FS);
        end else begin
          tick(dly);
          verdict(pass);
          check(exp_hs ? "R5 pass verdict (R7 edge)" : "R6 fail verdict", exp_hs ? E_HS : E_FS);
        end
      end
      verdict(!exp_hs);
      check("R10 final state holds", exp_hs ? E_HS : E_FS);
    end

    // restart during listening, full chirp again, stored verdict dropped
    restart();
    tick(3);
    verdict(1'b1);
    restart();
    check("R9 restart from chirp", E_CHIRP);
    tick(CHIRP_LEN - 1);
    check("R9 full length chirp", E_CHIRP);
    tick(1);
    check("R9 stored verdict dropped", E_LISTEN);
    tick(4);
    restart();
    check("R9 restart from listen", E_CHIRP);
    tick(CHIRP_LEN - 1);
    check("R9 full chirp after listen restart", E_CHIRP);
    tick(1);
    verdict(1'b1);
    check("R5 pass verdict", E_HS);
    restart();
    check("R9 restart from high speed", E_CHIRP);

    // asynchronous reset mid-chirp
    tick(5);
    #2 rst_n = 1'b0;
    #2;
    check("R1 reset mid chirp", E_IDLE);
    tick(1);
    rst_n = 1'b1;
    tick(3);
    check("R1 idle after reset", E_IDLE);

    finish_run();
  end

endmodule